// File: doc/BRIEF.md
# Leap-Forward Pattern Register

This block is a maximal-length shift-register pattern source with m stages. Each enabled clock advances it by a fixed number of single shifts rather than by one. The multi-shift next state is built as one flat XOR network. A single-step register moves its state by one companion-matrix multiplication. This register applies the leap-th power of that matrix in one cycle. Consecutive outputs are therefore less correlated than those of a plain one-shift register, which suits multiple-input-change test stimulus for built-in self test.

The feedback tap mask, the width and the leap count are parameters. One shift takes the parity of the stages selected by the tap mask and feeds it into stage 0, while every other stage moves up by one. A seed can be loaded at any time. An all-zero seed would lock the register, so the block replaces it with the default seed, which has stage 0 at 1 and every other stage at 0.

Top module: `lfsr_leap`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), state equals the default seed: bit 0 is 1 and all other bits are 0.
- R2: On a clock edge with en high and seed_valid low, state becomes the result of LEAP single shifts of its previous value. One shift is: new bit 0 = XOR of the bits selected by TAPS, and bits [m-1:1] take the old bits [m-2:0].
- R3: On a clock edge with en low and seed_valid low, state keeps its value.
- R4: On a clock edge with seed_valid high and a nonzero seed, state becomes that seed.
- R5: On a clock edge with seed_valid high and an all-zero seed, state becomes the default seed of R1.
- R6: When seed_valid and en are both high, the load takes effect and no shift is applied in that cycle.
- R7: After reset, state is never all-zero.
- R8: With the default parameters (m = 16, TAPS = 16'hB400, LEAP = 2, and LEAP coprime with 2^16-1), the register started from a seed first returns to that seed after exactly 65535 enabled clocks.
- R9: Reset takes priority over a seed load or an enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Advance the register by LEAP shifts |
| seed_valid | input | 1 | Load `seed` in this cycle |
| seed | input | WIDTH | Seed value. Zero is replaced by the default seed |
| state | output | WIDTH | Current register contents |

## Verification
Assertions check four behaviours on every cycle: that the register never holds zero, that it holds when idle, that loads take the seed or the default, and that an enabled cycle takes the leap network's output. They cannot show that the network really equals LEAP single shifts, or that the sequence is maximal. The bench shows both by running its own one-shift model LEAP times per clock over a full period. It also counts the clocks until the register first returns to the seed.

// File: rtl/lfsr_leap_pkg.sv
`timescale 1ns/1ps
// Shared defaults for the leap-forward pattern register.
// Assumes the tap mask describes a primitive polynomial for the width.
package lfsr_leap_pkg;
    localparam int unsigned DEF_WIDTH = 16;
    localparam logic [DEF_WIDTH-1:0] DEF_TAPS = 16'hB400;
    localparam int unsigned DEF_LEAP = 2;
endpackage

// File: rtl/lfsr_leap_step.sv
`timescale 1ns/1ps
// Combinational leap network: applies LEAP single shifts of the
// register in one flat XOR cone. Assumes LEAP >= 1 and a nonzero tap mask.
module lfsr_leap_step #(
    parameter int unsigned WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS = 16'hB400,
    parameter int unsigned LEAP = 2
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt
);
    // Unroll the one-shift feedback LEAP times.
    always_comb begin
        logic [WIDTH-1:0] s;
        s = cur;
        for (int k = 0; k < int'(LEAP); k++) begin
            s = {s[WIDTH-2:0], ^(s & TAPS)};
        end
        nxt = s;
        if (cur != '0) begin
            AST_STEP_NONZERO: assert (nxt != '0); // R7
        end
    end
endmodule

// File: rtl/lfsr_leap_seed.sv
`timescale 1ns/1ps
// Seed guard: passes a nonzero seed through, and replaces zero with the
// default seed (stage 0 set). Assumes WIDTH >= 2.
module lfsr_leap_seed #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] seed_in,
    output logic [WIDTH-1:0] seed_out
);
    localparam logic [WIDTH-1:0] SEED_DEF = WIDTH'(1);

    // Substitute the default when the seed would lock the register.
    always_comb begin
        seed_out = (seed_in == '0) ? SEED_DEF : seed_in;
    end
endmodule

// File: rtl/lfsr_leap.sv
`timescale 1ns/1ps
// Leap-forward pattern register: state advances LEAP shifts per enabled
// clock. Priority is reset, then seed load, then advance.
// Assumes a primitive tap mask and a synchronous active-low reset.
module lfsr_leap
    import lfsr_leap_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH,
    parameter logic [WIDTH-1:0] TAPS = DEF_TAPS,
    parameter int unsigned LEAP = DEF_LEAP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             seed_valid,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] state
);
    localparam logic [WIDTH-1:0] SEED_DEF = WIDTH'(1);

    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] q_leap;
    logic [WIDTH-1:0] seed_clean;

    lfsr_leap_step #(.WIDTH(WIDTH), .TAPS(TAPS), .LEAP(LEAP)) u_step (
        .cur (q),
        .nxt (q_leap)
    );

    lfsr_leap_seed #(.WIDTH(WIDTH)) u_seed (
        .seed_in  (seed),
        .seed_out (seed_clean)
    );

    // State register with reset > load > advance priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= SEED_DEF;
        end else if (seed_valid) begin
            q <= seed_clean;
        end else if (en) begin
            q <= q_leap;
        end
    end

    assign state = q;

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !seed_valid) |=> $stable(state)); // R3
    AST_LOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_valid && seed != '0) |=> state == $past(seed)); // R4
    AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_valid && seed == '0) |=> state == SEED_DEF); // R5
    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !seed_valid) |=> state == $past(q_leap)); // R2
endmodule

// File: tb/lfsr_leap_bench.sv
`timescale 1ns/1ps
// Bench for lfsr_leap: a table walk, then directed reset and period tests.
module lfsr_leap_bench;
    localparam int W = 16;
    localparam logic [W-1:0] TAPS = 16'hB400;
    localparam int LEAP = 2;
    localparam int PERIOD = 65535;
    localparam int NTBL = 12;
    // op codes: 0 idle, 1 advance, 2 load, 3 load with en
    localparam logic [17:0] TBL [NTBL] = '{
        {2'd1, 16'h0000}, {2'd1, 16'h0000}, {2'd0, 16'h0000},
        {2'd2, 16'hACE1}, {2'd1, 16'h0000}, {2'd1, 16'h0000},
        {2'd3, 16'h8000}, {2'd1, 16'h0000}, {2'd2, 16'h0000},
        {2'd0, 16'h1234}, {2'd3, 16'h0000}, {2'd1, 16'hFFFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic seed_valid = 1'b0;
    logic [W-1:0] seed = '0;
    logic [W-1:0] state;
    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] mdl;

    always #2 clk = ~clk;

    lfsr_leap #(.WIDTH(W), .TAPS(TAPS), .LEAP(LEAP)) u_lfsr_leap (
        .clk(clk), .rst_n(rst_n), .en(en), .seed_valid(seed_valid),
        .seed(seed), .state(state)
    );

    function automatic logic [W-1:0] one_shift(input logic [W-1:0] v);
        logic fb = 1'b0;
        for (int i = 0; i < W; i++) if (TAPS[i]) fb = fb ^ v[i];
        return {v[W-2:0], fb};
    endfunction

    function automatic logic [W-1:0] leap(input logic [W-1:0] v);
        logic [W-1:0] r = v;
        for (int k = 0; k < LEAP; k++) r = one_shift(r);
        return r;
    endfunction

    task automatic check(input string req, input logic [W-1:0] exp);
        n_cmp++;
        if (state !== exp) begin
            n_bad++;
            $display("FAIL %s: state=%h expected=%h", req, state, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 190000);
        n_bad++;
        $display("FAIL watchdog: state=%h expected=done", state);
        finish_run();
    end

    initial begin
        // R1: reset value
        repeat (2) @(posedge clk);
        #1 check("R1", 16'h0001);
        @(negedge clk) rst_n = 1'b1;
        mdl = 16'h0001;
        // Table walk
        for (int t = 0; t < NTBL; t++) begin
            logic [1:0] op;
            string req;
            op = TBL[t][17:16];
            @(negedge clk);
            seed = TBL[t][15:0];
            seed_valid = op[1];
            en = op[0];
            @(posedge clk);
            #1;
            if (op[1]) begin
                mdl = (seed == '0) ? 16'h0001 : seed;
                req = (seed == '0) ? "R5" : (op[0] ? "R6" : "R4");
            end else if (op[0]) begin
                mdl = leap(mdl);
                req = "R2";
            end else begin
                req = "R3";
            end
            check(req, mdl);
            if (state == '0) check("R7", 16'h0001);
        end
        // R9: reset wins over load and enable
        @(negedge clk);
        rst_n = 1'b0; seed_valid = 1'b1; en = 1'b1; seed = 16'h5A5A;
        @(posedge clk);
        #1 check("R9", 16'h0001);
        @(negedge clk);
        rst_n = 1'b1; seed_valid = 1'b1; en = 1'b0; seed = 16'h0001;
        @(posedge clk);
        // R8: full period from the default seed, R2 on every step
        @(negedge clk);
        seed_valid = 1'b0; en = 1'b1;
        mdl = 16'h0001;
        begin
            int first_ret = 0;
            for (int c = 1; c <= PERIOD; c++) begin
                @(posedge clk);
                #1;
                mdl = leap(mdl);
                if (state !== mdl) check("R2", mdl);
                if (first_ret == 0 && state == 16'h0001) first_ret = c;
            end
            n_cmp++;
            if (first_ret != PERIOD) begin
                n_bad++;
                $display("FAIL R8: first return=%0d expected=%0d", first_ret, PERIOD);
            end
            check("R2", mdl);
        end
        @(negedge clk) en = 1'b0;
        finish_run();
    end
endmodule